// File: doc/BRIEF.md
# Locked Memory Bus Arbiter

This block shares one memory between a processor with a pipelined address phase and a DMA master. The processor announces each access one cycle early: an active-low request, a size select (word or byte) and an active-low fetch flag, together with the address. The arbiter registers that announcement and drives the memory strobe, the access-type tag, the byte-lane enables and the address in the following cycle.

The DMA master takes the bus only at a safe point. The processor must have no access in flight, and its lock line must be low, so a read-then-write swap is never split. While DMA owns the bus, the arbiter pulls the processor's data-bus-enable low, which turns off its write-data drivers. If the processor announces an access during DMA ownership, the arbiter holds the processor with an active-low wait output and keeps the announced access pending. It completes that access in the first cycle after DMA lets go. The model uses a single clock edge per cycle.

Top module: `mem_lock_arbiter`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, the processor owns the bus: `dma_gnt`=0, `cpu_wait_n`=1, `cpu_dbe`=1, `mem_sel`=0, `mem_fetch`=0 and `mem_lanes`=0.
- R2: When `cpu_req_n` is 0 in cycle t and DMA does not own the bus in cycle t+1, `mem_sel` is 1 in cycle t+1 and `mem_addr` equals the `cpu_addr` sampled in cycle t. When `cpu_req_n` is 1 in cycle t, `mem_sel` is 0 in cycle t+1.
- R3: During a strobe, `mem_fetch` is 1 if `cpu_fetch_n` was 0 in the announcing cycle (instruction fetch) and 0 if it was 1 (data transfer). Without a strobe, `mem_fetch` is 0.
- R4: During a strobe, `mem_lanes` is all ones if `cpu_word` was 1 in the announcing cycle. If `cpu_word` was 0, only bit k of `mem_lanes` is set, where k is the value of the announced address bits [1:0]. Without a strobe, `mem_lanes` is 0.
- R5: A grant takes effect at a clock edge only under three conditions: `dma_req` is 1, the cycle before that edge carries no processor access, and `cpu_lock` is 0. `dma_gnt` is then 1 from the next cycle.
- R6: While `cpu_lock` is 1, no grant is given, even if `dma_req` is 1 and the processor is idle. The lock is honoured across every access of the swap.
- R7: Once given, the grant stays while `dma_req` is 1. It is removed in the cycle after the cycle in which `dma_req` is 0.
- R8: `cpu_dbe` is 0 in exactly the cycles where `dma_gnt` is 1.
- R9: An access announced while DMA owns the bus makes `cpu_wait_n` 0, with `mem_sel` 0, for as long as DMA keeps the bus. Processor inputs during that stall are ignored. In the first cycle after release, `cpu_wait_n` is 1 and the strobe appears with the originally announced address, size and type.
- R10: `mem_sel` and `dma_gnt` are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req_n | input | 1 | Active-low access announcement for the next cycle |
| cpu_word | input | 1 | Announced size: 1 word, 0 byte |
| cpu_fetch_n | input | 1 | Announced type: 0 instruction fetch, 1 data |
| cpu_lock | input | 1 | Processor holds the bus for a swap |
| cpu_addr | input | ADDR_W | Announced address |
| dma_req | input | 1 | DMA master bus request |
| dma_gnt | output | 1 | DMA master owns the bus |
| cpu_dbe | output | 1 | Processor write-data driver enable, low while DMA owns the bus |
| cpu_wait_n | output | 1 | Active-low stall to the processor |
| mem_sel | output | 1 | Memory strobe for a processor access in this cycle |
| mem_fetch | output | 1 | Strobed access is an instruction fetch |
| mem_lanes | output | LANES | Byte-lane enables of the strobed access |
| mem_addr | output | ADDR_W | Address of the registered processor access |

## Verification
The main function is driven with three patterns. A back-to-back stream of word fetches and byte data accesses at all four low-address values shows that the one-cycle-late strobe carries the right size, type and lane for each announcement. DMA requests raised in idle, busy and locked cycles tell apart a grant that waits for an idle processor from one that waits for lock to drop. An announcement made during DMA ownership, followed by changed processor inputs and a release, shows that the stalled access survives intact and completes exactly one cycle after release. A reset taken during DMA ownership checks the return to processor ownership.

// File: rtl/mla_pkg.sv
package mla_pkg;
   typedef enum logic {
      OWNER_CPU = 1'b0,
      OWNER_DMA = 1'b1
   } owner_e;
endpackage

// File: rtl/mla_req_pipe.sv
// Registers the processor's early announcement; freezes it while stalled.
module mla_req_pipe #(
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ann_req_n,
   input  logic              ann_word,
   input  logic              ann_fetch_n,
   input  logic [ADDR_W-1:0] ann_addr,
   input  logic              dma_owns,
   output logic              pend,
   output logic              pend_word,
   output logic              pend_fetch,
   output logic [ADDR_W-1:0] pend_addr,
   output logic              stall
);
   assign stall = pend && dma_owns;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend       <= 1'b0;
         pend_word  <= 1'b1;
         pend_fetch <= 1'b0;
         pend_addr  <= '0;
      end else if (!stall) begin
         pend <= !ann_req_n;
         if (!ann_req_n) begin
            pend_word  <= ann_word;
            pend_fetch <= !ann_fetch_n;
            pend_addr  <= ann_addr;
         end
      end
   end

   // R9: a stalled access keeps all of its attributes
   assert_stall_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
      stall |=> (pend && $stable(pend_addr) && $stable(pend_word) && $stable(pend_fetch)));
endmodule

// File: rtl/mla_owner.sv
// Bus ownership: hands the bus to DMA only at an idle, unlocked point.
module mla_owner
   import mla_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   dma_req,
   input  logic   lock,
   input  logic   busy,
   output owner_e owner,
   output logic   dma_gnt,
   output logic   dbe
);
   owner_e owner_nx;

   always_comb begin
      owner_nx = owner;
      unique case (owner)
         OWNER_CPU: if (dma_req && !lock && !busy) owner_nx = OWNER_DMA;
         OWNER_DMA: if (!dma_req)                  owner_nx = OWNER_CPU;
         default:   owner_nx = OWNER_CPU;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) owner <= OWNER_CPU;
      else        owner <= owner_nx;
   end

   assign dma_gnt = (owner == OWNER_DMA);
   assign dbe     = (owner == OWNER_CPU);

   assert_no_grant_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!dma_gnt && busy) |=> !dma_gnt);
   assert_no_grant_locked_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!dma_gnt && lock) |=> !dma_gnt);
   assert_grant_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (dma_gnt && dma_req) |=> dma_gnt);
   assert_grant_dropped_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (dma_gnt && !dma_req) |=> !dma_gnt);
endmodule

// File: rtl/mla_lane_dec.sv
// Byte-lane enables: all lanes for a word, one lane for a byte.
module mla_lane_dec #(
   parameter int ADDR_W = 32,
   parameter int LANES  = 4
) (
   input  logic              sel,
   input  logic              word,
   input  logic [ADDR_W-1:0] addr,
   output logic [LANES-1:0]  lanes
);
   localparam int LB = $clog2(LANES);

   generate
      if (LANES < 2 || (1 << LB) != LANES) begin : g_bad_lanes
         $error("mla_lane_dec: LANES must be a power of two, at least 2");
      end
      for (genvar i = 0; i < LANES; i++) begin : g_lane
         assign lanes[i] = sel && (word || (addr[LB-1:0] == LB'(i)));
      end
   endgenerate

   always_comb begin
      if (sel && !word) begin
         assert_byte_onehot_R4: assert ($countones(lanes) == 1);
      end
      if (!sel) begin
         assert_idle_no_lanes_R4: assert (lanes == '0);
      end
   end
endmodule

// File: rtl/mem_lock_arbiter.sv
module mem_lock_arbiter
   import mla_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int LANES  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req_n,
   input  logic              cpu_word,
   input  logic              cpu_fetch_n,
   input  logic              cpu_lock,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic              dma_req,
   output logic              dma_gnt,
   output logic              cpu_dbe,
   output logic              cpu_wait_n,
   output logic              mem_sel,
   output logic              mem_fetch,
   output logic [LANES-1:0]  mem_lanes,
   output logic [ADDR_W-1:0] mem_addr
);
   localparam int LB = $clog2(LANES);

   generate
      if (ADDR_W < LB) begin : g_bad_addr
         $error("mem_lock_arbiter: ADDR_W too narrow for LANES");
      end
   endgenerate

   owner_e owner;
   logic   pend, pend_word, pend_fetch, stall;

   mla_req_pipe #(.ADDR_W(ADDR_W)) u_pipe (
      .clk(clk), .rst_n(rst_n),
      .ann_req_n(cpu_req_n), .ann_word(cpu_word), .ann_fetch_n(cpu_fetch_n),
      .ann_addr(cpu_addr), .dma_owns(owner == OWNER_DMA),
      .pend(pend), .pend_word(pend_word), .pend_fetch(pend_fetch),
      .pend_addr(mem_addr), .stall(stall)
   );

   mla_owner u_owner (
      .clk(clk), .rst_n(rst_n),
      .dma_req(dma_req), .lock(cpu_lock), .busy(pend),
      .owner(owner), .dma_gnt(dma_gnt), .dbe(cpu_dbe)
   );

   assign mem_sel    = pend && (owner == OWNER_CPU);
   assign mem_fetch  = mem_sel && pend_fetch;
   assign cpu_wait_n = !stall;

   mla_lane_dec #(.ADDR_W(ADDR_W), .LANES(LANES)) u_lanes (
      .sel(mem_sel), .word(pend_word), .addr(mem_addr), .lanes(mem_lanes)
   );

   // R9: releasing the bus completes the stalled access in the next cycle
   assert_release_completes_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!cpu_wait_n && !dma_req) |=> (cpu_wait_n && mem_sel));
   // R8: a stall only occurs while the processor's drivers are off
   assert_wait_dbe_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !cpu_wait_n |-> !cpu_dbe);
endmodule

// File: tb/test_mem_lock_arbiter.sv
module test_mem_lock_arbiter;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        cpu_req_n, cpu_word, cpu_fetch_n, cpu_lock, dma_req;
   logic [31:0] cpu_addr;
   logic        dma_gnt, cpu_dbe, cpu_wait_n, mem_sel, mem_fetch;
   logic [3:0]  mem_lanes;
   logic [31:0] mem_addr;
   int          n_cmp = 0;
   int          n_bad = 0;
   bit          done  = 1'b0;

   always #5 clk = ~clk;

   mem_lock_arbiter i_mem_lock_arbiter (
      .clk(clk), .rst_n(rst_n), .cpu_req_n(cpu_req_n), .cpu_word(cpu_word),
      .cpu_fetch_n(cpu_fetch_n), .cpu_lock(cpu_lock), .cpu_addr(cpu_addr),
      .dma_req(dma_req), .dma_gnt(dma_gnt), .cpu_dbe(cpu_dbe),
      .cpu_wait_n(cpu_wait_n), .mem_sel(mem_sel), .mem_fetch(mem_fetch),
      .mem_lanes(mem_lanes), .mem_addr(mem_addr)
   );

   // {req_n,word,fetch_n,lock,dma}, addr, {sel,fetch,lanes[3:0],gnt,wait_n,dbe}, expected addr
   // Expected outputs are those seen before the row's inputs are applied.
   localparam int NV = 20;
   localparam logic [29:0] VEC [NV] = '{
      {5'b11100, 8'h00, 9'b000000011, 8'h00},  // 0 idle after reset
      {5'b01000, 8'h10, 9'b000000011, 8'h00},  // 1 announce word fetch
      {5'b00100, 8'h21, 9'b111111011, 8'h10},  // 2 byte data announced
      {5'b00100, 8'h33, 9'b100010011, 8'h21},  // 3 lane 1
      {5'b11100, 8'h00, 9'b101000011, 8'h33},  // 4 lane 3
      {5'b11101, 8'h00, 9'b000000011, 8'h33},  // 5 idle + dma: grant
      {5'b11101, 8'h00, 9'b000000110, 8'h33},  // 6 dma owns (R7 held)
      {5'b01101, 8'h44, 9'b000000110, 8'h33},  // 7 word data announced under dma
      {5'b00001, 8'h55, 9'b000000100, 8'h44},  // 8 stalled, inputs changed
      {5'b00000, 8'h55, 9'b000000100, 8'h44},  // 9 dma drops (R7)
      {5'b11101, 8'h00, 9'b101111011, 8'h44},  // 10 stalled access completes; busy blocks grant
      {5'b11101, 8'h00, 9'b000000011, 8'h44},  // 11 idle: grant
      {5'b11100, 8'h00, 9'b000000110, 8'h44},  // 12 dma owns, drops request
      {5'b11111, 8'h00, 9'b000000011, 8'h44},  // 13 lock high: R6 no grant
      {5'b00111, 8'h62, 9'b000000011, 8'h44},  // 14 locked swap read
      {5'b00111, 8'h63, 9'b100100011, 8'h62},  // 15 locked swap write, lane 2
      {5'b11101, 8'h00, 9'b101000011, 8'h63},  // 16 lock low but busy
      {5'b11101, 8'h00, 9'b000000011, 8'h63},  // 17 idle unlocked: grant
      {5'b11100, 8'h00, 9'b000000110, 8'h63},  // 18 dma releases
      {5'b11100, 8'h00, 9'b000000011, 8'h63}   // 19 processor owns again
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   task automatic chk_reset_state();
      chk("R1 dma_gnt", 32'(dma_gnt), 32'd0);
      chk("R1 cpu_wait_n", 32'(cpu_wait_n), 32'd1);
      chk("R1 cpu_dbe", 32'(cpu_dbe), 32'd1);
      chk("R1 mem_sel", 32'(mem_sel), 32'd0);
      chk("R1 mem_fetch", 32'(mem_fetch), 32'd0);
      chk("R1 mem_lanes", 32'(mem_lanes), 32'd0);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      rst_n = 1'b0; cpu_req_n = 1'b1; cpu_word = 1'b1; cpu_fetch_n = 1'b1;
      cpu_lock = 1'b0; dma_req = 1'b0; cpu_addr = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk_reset_state();
      rst_n = 1'b1;

      for (int k = 0; k < NV; k++) begin
         logic [29:0] v;
         v = VEC[k];
         @(negedge clk);
         chk("R2 mem_sel", 32'(mem_sel), 32'(v[16]));
         chk("R2 R9 mem_addr", mem_addr, {24'h0, v[7:0]});
         chk("R3 mem_fetch", 32'(mem_fetch), 32'(v[15]));
         chk("R4 mem_lanes", 32'(mem_lanes), 32'(v[14:11]));
         chk("R5 R6 R7 dma_gnt", 32'(dma_gnt), 32'(v[10]));
         chk("R9 cpu_wait_n", 32'(cpu_wait_n), 32'(v[9]));
         chk("R8 cpu_dbe", 32'(cpu_dbe), 32'(v[8]));
         chk("R10 overlap", 32'(mem_sel && dma_gnt), 32'd0);
         {cpu_req_n, cpu_word, cpu_fetch_n, cpu_lock, dma_req} = v[29:25];
         cpu_addr = {24'h0, v[24:17]};
      end

      // Reset taken while DMA owns the bus (R1)
      @(negedge clk);
      cpu_req_n = 1'b1; cpu_lock = 1'b0; dma_req = 1'b1;
      @(negedge clk);
      @(negedge clk);
      chk("R5 dma_gnt before reset", 32'(dma_gnt), 32'd1);
      rst_n = 1'b0;
      #1;
      chk_reset_state();
      @(negedge clk);
      rst_n = 1'b1; dma_req = 1'b0;
      // Byte access at lane 0 (R4)
      cpu_req_n = 1'b0; cpu_word = 1'b0; cpu_fetch_n = 1'b1; cpu_addr = 32'h0000_0A00;
      @(negedge clk);
      cpu_req_n = 1'b1;
      chk("R4 lane0 mem_lanes", 32'(mem_lanes), 32'h1);
      chk("R2 lane0 mem_addr", mem_addr, 32'h0000_0A00);
      @(negedge clk);
      chk("R2 idle mem_sel", 32'(mem_sel), 32'd0);
      finish_run();
   end
endmodule